// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers request flags from seven peripheral sources and turns them into one vectored call request for a CPU core. The sources are two timer-module events, a low-supply detector, ADC conversion done, EEPROM write done and two periodic time-base overflows. Each source reaches the block as a single-cycle event pulse. The pulse latches a sticky flag. A flag becomes a call only when three conditions hold: its own enable bit is set, the global enable bit is set, and the core's return stack has room.

The block offers one call at a time on `call_req_o`, with the source index on `call_vec_o`. The core turns that index into its fixed vector address. The request and its index stay stable until the core pulses `call_ack_i`. On that acknowledge the hardware clears two things: the flag of the serviced source and the global enable. Clearing the global enable stops any other interrupt from nesting, and any flag held back in this way waits until software sets the global enable again. Software reaches the flags, the enables and the global enable through a small register port. Source indices: 0 and 1 are the timer events, 2 is low supply, 3 is ADC done, 4 is EEPROM done, and 5 and 6 are the time bases.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset all flags, all source enables and the global enable read as 0, and `call_req_o` is low.
- R2: An event pulse on `evt_i[i]` sets flag bit i, and the new value reads back at register address 0 one clock after the pulse.
- R3: A register write to address 0 loads the flags from the write data, bit i holding source i. A 1 sets a flag and a 0 clears it. An event pulse in the same cycle as a clearing write leaves that flag set.
- R4: Address 1 holds the source enable bits (bit i for source i) and address 2 bit 0 holds the global enable. Both are writable and read back on `reg_rdata_o` for the addressed register in the same cycle; unused bits and address 3 read 0.
- R5: When `call_req_o` is low and a flag has its enable set, the global enable is set and `stack_full_i` is low, `call_req_o` rises at the next clock. `call_vec_o` then carries that source's index.
- R6: No call is raised while `stack_full_i` is high. The flag stays pending and is called on the first clock at which the stack is no longer full.
- R7: No call is raised while the global enable is clear or while no pending flag has its source enable set.
- R8: When several enabled flags are pending, the lowest-numbered source is called.
- R9: `call_req_o` and `call_vec_o` hold their values until a clock at which `call_ack_i` is high, and `call_req_o` is low after that clock. An acknowledge while no request is up has no effect.
- R10: An acknowledge clears the serviced source's flag (unless its event pulses in the same cycle) and the global enable. It leaves the other flags unchanged.
- R11: A flag held back by a cleared global enable stays set and is called once software sets the global enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Single-cycle event pulses, one per source |
| stack_full_i | input | 1 | Core return stack has no free entry |
| call_ack_i | input | 1 | Core accepts the pending call |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 flags, 1 enables, 2 control |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the addressed register |
| call_req_o | output | 1 | Vectored call request to the core |
| call_vec_o | output | 3 | Index of the source being called |

## Verification
Every state change lands on the clock edge that samples its cause. Flags, enables and the global enable therefore appear on the combinational read port one cycle after an event, write or acknowledge. A call needs a second register stage, so it rises one cycle after the flag is visible, which is two cycles after the event pulse. The bench drives inputs on the falling edge and updates its own model of the flags, enables, global enable and pending call once per rising edge. It compares the request, the index and the read data on the next falling edge. The directed checks rely on that same two-cycle event-to-call count, so a latency off by one stage is reported.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_FLAG = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;

  localparam int unsigned CTRL_GIE_BIT = 0;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned VEC_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               flag_we_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic               clr_i,
  input  logic [VEC_W-1:0]   clr_idx_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] mask_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic flag_q, mask_q, base, hit_clr;

    assign hit_clr = clr_i && (clr_idx_i == VEC_W'(g));
    assign base    = flag_we_i ? wdata_i[g] : flag_q;

    // hardware set wins over both software clear and service clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= (base & ~hit_clr) | evt_i[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mask_q <= 1'b0;
      else if (mask_we_i) mask_q <= wdata_i[g];
    end

    assign flag_o[g] = flag_q;
    assign mask_o[g] = mask_q;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned VEC_W   = 3
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               any_o,
  output logic [VEC_W-1:0]   idx_o
);
  // scan downward so the lowest set index is written last
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = VEC_W'(i);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/irq_call_ctl.sv
module irq_call_ctl #(
  parameter int unsigned VEC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gie_we_i,
  input  logic             gie_wdata_i,
  input  logic             pend_any_i,
  input  logic [VEC_W-1:0] pend_idx_i,
  input  logic             stack_full_i,
  input  logic             ack_i,
  output logic             gie_o,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             serviced_o
);
  logic             gie_q, req_q, launch;
  logic [VEC_W-1:0] vec_q;

  assign serviced_o = req_q && ack_i;
  assign launch     = !req_q && gie_q && pend_any_i && !stack_full_i;

  // service clear beats a software write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gie_q <= 1'b0;
    else if (serviced_o) gie_q <= 1'b0;
    else if (gie_we_i)   gie_q <= gie_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else if (serviced_o) begin
      req_q <= 1'b0;
    end else if (launch) begin
      req_q <= 1'b1;
      vec_q <= pend_idx_i;
    end
  end

  assign gie_o = gie_q;
  assign req_o = req_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned VEC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               stack_full_i,
  input  logic               call_ack_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               call_req_o,
  output logic [VEC_W-1:0]   call_vec_o
);
  logic [NUM_SRC-1:0] flag_q, mask_q, pend;
  logic               gie_q, pend_any, serviced;
  logic [VEC_W-1:0]   pend_idx;
  logic               we_flag, we_mask, we_ctrl;

  assign we_flag = reg_we_i && (reg_addr_i == SEL_FLAG);
  assign we_mask = reg_we_i && (reg_addr_i == SEL_MASK);
  assign we_ctrl = reg_we_i && (reg_addr_i == SEL_CTRL);

  irq_flag_bank #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .flag_we_i (we_flag),
    .mask_we_i (we_mask),
    .wdata_i   (reg_wdata_i[NUM_SRC-1:0]),
    .clr_i     (serviced),
    .clr_idx_i (call_vec_o),
    .flag_o    (flag_q),
    .mask_o    (mask_q)
  );

  assign pend = flag_q & mask_q;

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_prio (
    .pend_i (pend),
    .any_o  (pend_any),
    .idx_o  (pend_idx)
  );

  irq_call_ctl #(.VEC_W(VEC_W)) u_call (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gie_we_i     (we_ctrl),
    .gie_wdata_i  (reg_wdata_i[CTRL_GIE_BIT]),
    .pend_any_i   (pend_any),
    .pend_idx_i   (pend_idx),
    .stack_full_i (stack_full_i),
    .ack_i        (call_ack_i),
    .gie_o        (gie_q),
    .req_o        (call_req_o),
    .vec_o        (call_vec_o),
    .serviced_o   (serviced)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      SEL_FLAG: reg_rdata_o = DATA_W'(flag_q);
      SEL_MASK: reg_rdata_o = DATA_W'(mask_q);
      SEL_CTRL: reg_rdata_o[CTRL_GIE_BIT] = gie_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned VEC_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               stack_full_i,
  input logic               call_ack_i,
  input logic               call_req_o,
  input logic [VEC_W-1:0]   call_vec_o,
  input logic [NUM_SRC-1:0] flag_q,
  input logic               gie_q
);
  assert_hold_until_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_req_o && !call_ack_i) |=> (call_req_o && $stable(call_vec_o)));

  assert_ack_drops_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_req_o && call_ack_i) |=> !call_req_o);

  assert_no_call_when_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!call_req_o && stack_full_i) |=> !call_req_o);

  assert_no_call_without_gie_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!call_req_o && !gie_q) |=> !call_req_o);

  assert_ack_clears_gie_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_req_o && call_ack_i) |=> !gie_q);

  assert_ack_clears_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_req_o && call_ack_i && !evt_i[call_vec_o]) |=> !flag_q[$past(call_vec_o)]);

  assert_event_sets_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[0] |=> flag_q[0]);

  assert_vec_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |-> (32'(call_vec_o) < NUM_SRC));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_i        (evt_i),
  .stack_full_i (stack_full_i),
  .call_ack_i   (call_ack_i),
  .call_req_o   (call_req_o),
  .call_vec_o   (call_vec_o),
  .flag_q       (flag_q),
  .gie_q        (gie_q)
);

// File: tb/test_irq_vec_ctrl.sv
`timescale 1ns/1ps
module test_irq_vec_ctrl;
  localparam int N = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic       full = 1'b0, ack = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = '0, rdata;
  logic       call_req;
  logic [2:0] call_vec;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [N-1:0] m_flag = '0, m_mask = '0;
  logic         m_gie = 0, m_req = 0;
  logic [2:0]   m_vec = '0;

  always #4 clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .stack_full_i(full),
    .call_ack_i(ack), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .call_req_o(call_req), .call_vec_o(call_vec)
  );

  function automatic logic [2:0] lowest(input logic [N-1:0] v);
    for (int i = N - 1; i >= 0; i--) if (v[i]) lowest = 3'(i);
    if (v == '0) lowest = '0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: exp_rd = 8'(m_flag);
      2'd1: exp_rd = 8'(m_mask);
      2'd2: exp_rd = {7'd0, m_gie};
      default: exp_rd = 8'd0;
    endcase
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // model of one rising edge, from the requirements
  task automatic model_edge();
    logic [N-1:0] nf;
    logic [N-1:0] pend;
    logic svc;
    svc  = m_req && ack;
    pend = m_flag & m_mask;
    nf = (we && addr == 2'd0) ? wdata[N-1:0] : m_flag;
    if (svc) nf[m_vec] = 1'b0;
    nf = nf | evt;
    if (svc) m_req = 1'b0;
    else if (!m_req && m_gie && (pend != '0) && !full) begin
      m_req = 1'b1;
      m_vec = lowest(pend);
    end
    if (svc) m_gie = 1'b0;
    else if (we && addr == 2'd2) m_gie = wdata[0];
    if (we && addr == 2'd1) m_mask = wdata[N-1:0];
    m_flag = nf;
  endtask

  task automatic cyc(input logic [N-1:0] e, input logic f, input logic a,
                     input logic w, input logic [1:0] ad, input logic [7:0] wd);
    evt = e; full = f; ack = a; we = w; addr = ad; wdata = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R9 request", int'(call_req), int'(m_req));
    if (m_req) chk("R8 vector", int'(call_vec), int'(m_vec));
    chk("R4 read data", int'(rdata), int'(exp_rd(ad)));
  endtask

  task automatic idle(input logic [1:0] ad);
    cyc('0, 1'b0, 1'b0, 1'b0, ad, 8'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 req in reset", int'(call_req), 0);
    chk("R1 flags in reset", int'(rdata), 0);
    rst_n = 1'b1;
    idle(2'd1); chk("R1 enables", int'(rdata), 0);
    idle(2'd2); chk("R1 global enable", int'(rdata), 0);

    cyc('0, 0, 0, 1, 2'd1, 8'h7F); chk("R4 enables write", int'(rdata), 8'h7F);
    cyc('0, 0, 0, 1, 2'd2, 8'h01); chk("R4 gie write", int'(rdata), 1);
    chk("R7 no flag no call", int'(call_req), 0);

    cyc(7'h08, 0, 0, 0, 2'd0, 0);
    chk("R2 event sets flag", int'(rdata), 8'h08);
    chk("R5 not yet", int'(call_req), 0);
    idle(2'd0);
    chk("R5 call up", int'(call_req), 1); chk("R5 vector", int'(call_vec), 3);

    cyc(7'h02, 0, 0, 0, 2'd0, 0);
    chk("R9 hold vec", int'(call_vec), 3);
    idle(2'd0); idle(2'd0);
    chk("R9 still held", int'(call_req), 1); chk("R9 vec stable", int'(call_vec), 3);
    chk("R2 both flags", int'(rdata), 8'h0A);

    cyc('0, 0, 1, 0, 2'd0, 0);
    chk("R9 ack drops", int'(call_req), 0);
    chk("R10 flag cleared", int'(rdata), 8'h02);
    idle(2'd2); chk("R10 gie cleared", int'(rdata), 0);
    repeat (3) idle(2'd0);
    chk("R7 gie off no call", int'(call_req), 0);

    cyc('0, 1, 0, 1, 2'd2, 8'h01);
    repeat (3) cyc('0, 1, 0, 0, 2'd0, 0);
    chk("R6 full blocks", int'(call_req), 0);
    chk("R6 still pending", int'(rdata), 8'h02);
    idle(2'd0);
    chk("R11 call after gie", int'(call_req), 1); chk("R11 vector", int'(call_vec), 1);
    cyc('0, 0, 1, 0, 2'd0, 0);
    chk("R10 flags empty", int'(rdata), 0);

    cyc('0, 0, 0, 1, 2'd0, 8'h60);
    cyc('0, 0, 0, 1, 2'd2, 8'h01);
    idle(2'd0);
    chk("R8 lowest wins", int'(call_vec), 5);
    cyc('0, 0, 1, 0, 2'd0, 0);
    idle(2'd0);
    chk("R10 other flag kept", int'(rdata), 8'h40);

    cyc(7'h04, 0, 0, 1, 2'd0, 8'h00);
    chk("R3 event beats clear", int'(rdata), 8'h04);
    cyc('0, 0, 0, 1, 2'd0, 8'h11);
    chk("R3 write sets", int'(rdata), 8'h11);

    cyc('0, 0, 0, 1, 2'd1, 8'h00);
    cyc('0, 0, 0, 1, 2'd2, 8'h01);
    repeat (3) idle(2'd0);
    chk("R7 masked no call", int'(call_req), 0);
    cyc('0, 0, 0, 1, 2'd1, 8'h10);
    idle(2'd0);
    chk("R7 enabled source", int'(call_req), 1); chk("R7 vector", int'(call_vec), 4);
    cyc('0, 0, 1, 0, 2'd0, 0);
    cyc('0, 0, 1, 0, 2'd0, 0);
    chk("R9 stray ack", int'(call_req), 0);

    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] e;
      logic w;
      logic [1:0] ad;
      logic [7:0] wd;
      e = '0;
      for (int b = 0; b < N; b++) e[b] = ($urandom % 20) == 0;
      w  = ($urandom % 10) == 0;
      ad = 2'($urandom % 4);
      wd = 8'($urandom);
      if (($urandom % 8) == 0) begin w = 1; ad = 2'd2; wd = 8'h01; end
      cyc(e, ($urandom % 5) == 0, ($urandom % 3) == 0, w, ad, wd);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule